// File: doc/BRIEF.md
# I2C Paired-Register Target for a 16-bit I/O Expander

This block is the serial front end of a 16-bit general-purpose I/O expander. It watches an oversampled two-wire bus (clock and data, both sampled by the system clock). It answers its own 7-bit address and keeps eight byte-wide registers. A write carries the address with a direction bit of 0, then a command byte that selects a register, then any number of data bytes. A read first sends the address and the command byte as a write. It then issues a repeated START and the address with the direction bit set, and the target streams register contents back until the controller refuses a byte.

The eight registers form four pairs: input, output, polarity inversion and direction (configuration). Each pair holds one byte for the low port (pins 7:0) and one for the high port (pins 15:8). After every data byte the register pointer moves to the other member of its pair, never to the next pair. A long stream therefore alternates between two registers with no length limit. The output and direction registers appear on parallel buses. The input registers reflect the pins, corrected by the polarity registers.

Top module: `ioxp_port_ctrl`

## Requirements
- R1: After a START, the first 7 bits received are compared with parameter DEV_ADDR. On a match the target acknowledges (pulls SDA low during the 9th clock). On a mismatch it does not acknowledge and ignores the bus until the next START.
- R2: A command byte with value 0 to 7 is acknowledged and becomes the register pointer. A value of 8 or more is not acknowledged, and later bytes are neither acknowledged nor stored until the next START.
- R3: Each written data byte is acknowledged and stored into the register the pointer names. The pointer then becomes itself with bit 0 inverted, for any number of bytes. For example, command 7 stores into 7, then 6, then 7 again.
- R4: After a repeated START and a matching address with the direction bit 1, the target sends the pointed register MSB first. Each byte the controller acknowledges is followed by the other register of the pair. After a byte that is not acknowledged, the target releases SDA and sends nothing more.
- R5: Commands 0 and 1 name the read-only input registers. Data bytes written there are acknowledged but change no register.
- R6: Command values: 0/1 input, 2/3 output, 4/5 polarity, 6/7 direction. An even value is the low port (bus bits 7:0) and an odd value is the high port (bits 15:8). Output registers drive `drive_o` and direction registers drive `dir_o`. An input register reads as the pin byte XOR the polarity byte of the same port, captured when the byte is loaded.
- R7: After reset, the output registers hold 0xFF, the polarity registers hold 0x00 and the direction registers hold 0xFF, and SDA is released.
- R8: START is a falling SDA while SCL is high, and STOP is a rising SDA while SCL is high. A STOP in any state returns the target to idle with SDA released and leaves the registers as they were.
- R9: The target changes its SDA pull only while SCL is low. Acknowledge and read data are driven from the SCL fall that ends the previous bit. A byte is written, or the next read byte is loaded, at the falling edge of the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level as seen at the pad |
| sda_i | input | 1 | Bus data level as seen at the pad |
| sda_pull_o | output | 1 | 1 enables the pull-down on the data line |
| pins_i | input | 16 | Port pin levels, low port in bits 7:0 |
| drive_o | output | 16 | Output register contents, low port in bits 7:0 |
| dir_o | output | 16 | Direction register contents, 1 = input |

## Verification
The bench builds the block with DEV_ADDR = 7'h5A, which differs from the default, and with SYNC_STAGES = 3. The first setting shows that the address match comes from the parameter and not from a fixed constant. The second adds a cycle of sampling latency, so every acknowledge and read bit must still land inside a quarter-bit of ten system clocks. At these settings, long alternating streams, pointer reuse across a repeated START, rejected commands and a STOP in the middle of a byte all fit in a short run.

// File: rtl/ioxp_pkg.sv
package ioxp_pkg;
  localparam int BYTE_W = 8;
  localparam int NPORT  = 2;
  localparam int PORT_W = BYTE_W * NPORT;
  localparam int IDX_W  = 3;

  localparam logic [1:0] GRP_IN  = 2'd0;
  localparam logic [1:0] GRP_OUT = 2'd1;
  localparam logic [1:0] GRP_POL = 2'd2;
  localparam logic [1:0] GRP_CFG = 2'd3;

  localparam logic [BYTE_W-1:0] OUT_RST = 8'hFF;
  localparam logic [BYTE_W-1:0] POL_RST = 8'h00;
  localparam logic [BYTE_W-1:0] CFG_RST = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } link_st_e;

  // other member of the same register pair
  function automatic logic [IDX_W-1:0] pair_mate(input logic [IDX_W-1:0] idx);
    return {idx[IDX_W-1:1], ~idx[0]};
  endfunction

  // command byte names one of the eight registers
  function automatic logic cmd_ok(input logic [BYTE_W-1:0] c);
    return c[BYTE_W-1:IDX_W] == '0;
  endfunction

  function automatic logic [BYTE_W-1:0] apply_pol(input logic [BYTE_W-1:0] pin,
                                                  input logic [BYTE_W-1:0] pol);
    return pin ^ pol;
  endfunction
endpackage

// File: rtl/ioxp_sync.sv
module ioxp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ioxp_bus_evt.sv
module ioxp_bus_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  assign ev_rise  =  scl_s & ~scl_d;
  assign ev_fall  = ~scl_s &  scl_d;
  assign ev_start =  scl_s &  scl_d &  sda_d & ~sda_s;
  assign ev_stop  =  scl_s &  scl_d & ~sda_d &  sda_s;
endmodule

// File: rtl/ioxp_regs.sv
module ioxp_regs
  import ioxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [PORT_W-1:0] pins,
  output logic [BYTE_W-1:0] rd_data,
  output logic [PORT_W-1:0] drive_bus,
  output logic [PORT_W-1:0] dir_bus
);
  logic [PORT_W-1:0] pol_bus;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [BYTE_W-1:0] out_r, pol_r, cfg_r;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          out_r <= OUT_RST;
          pol_r <= POL_RST;
          cfg_r <= CFG_RST;
        end else if (wr_en && wr_idx[0] == 1'(p)) begin
          unique case (wr_idx[IDX_W-1:1])
            GRP_OUT: out_r <= wr_data;
            GRP_POL: pol_r <= wr_data;
            GRP_CFG: cfg_r <= wr_data;
            default: ;  // input pair is read-only
          endcase
        end

      assign drive_bus[p*BYTE_W +: BYTE_W] = out_r;
      assign pol_bus[p*BYTE_W +: BYTE_W]   = pol_r;
      assign dir_bus[p*BYTE_W +: BYTE_W]   = cfg_r;
    end
  endgenerate

  logic rd_port;
  assign rd_port = rd_idx[0];

  always_comb begin
    unique case (rd_idx[IDX_W-1:1])
      GRP_IN:  rd_data = apply_pol(pins[rd_port*BYTE_W +: BYTE_W],
                                   pol_bus[rd_port*BYTE_W +: BYTE_W]);
      GRP_OUT: rd_data = drive_bus[rd_port*BYTE_W +: BYTE_W];
      GRP_POL: rd_data = pol_bus[rd_port*BYTE_W +: BYTE_W];
      default: rd_data = dir_bus[rd_port*BYTE_W +: BYTE_W];
    endcase
  end
endmodule

// File: rtl/ioxp_link.sv
module ioxp_link
  import ioxp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic [IDX_W-1:0]  ptr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ev_addr_miss,
  output logic              ev_cmd_reject,
  output link_st_e          st
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              rw;
  logic              byte_in;

  assign byte_in       = (bitcnt == CNT_FULL);
  assign ev_addr_miss  = (st == ST_ADDR) && ev_fall && byte_in &&
                         (shreg[BYTE_W-1:1] != DEV_ADDR);
  assign ev_cmd_reject = (st == ST_CMD) && ev_fall && byte_in && !cmd_ok(shreg);
  assign wr_en         = (st == ST_WDATA_ACK) && ev_fall;
  assign wr_idx        = ptr;
  assign wr_data       = shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      rw       <= 1'b0;
      ptr      <= '0;
      sda_pull <= 1'b0;
    end else if (ev_stop) begin
      st       <= ST_IDLE;
      sda_pull <= 1'b0;
    end else if (ev_start) begin
      st       <= ST_ADDR;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (ev_rise && !byte_in) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (ev_fall && byte_in) begin
            if (st == ST_ADDR) begin
              if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                sda_pull <= 1'b1;
                rw       <= shreg[0];
                st       <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_CMD) begin
              if (cmd_ok(shreg)) begin
                sda_pull <= 1'b1;
                ptr      <= shreg[IDX_W-1:0];
                st       <= ST_CMD_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              sda_pull <= 1'b1;
              st       <= ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (ev_fall) begin
          bitcnt <= '0;
          if (rw) begin
            shreg    <= rd_data;
            sda_pull <= ~rd_data[BYTE_W-1];
            st       <= ST_RDATA;
          end else begin
            sda_pull <= 1'b0;
            st       <= ST_CMD;
          end
        end
        ST_CMD_ACK: if (ev_fall) begin
          sda_pull <= 1'b0;
          bitcnt   <= '0;
          st       <= ST_WDATA;
        end
        ST_WDATA_ACK: if (ev_fall) begin
          sda_pull <= 1'b0;
          bitcnt   <= '0;
          ptr      <= pair_mate(ptr);
          st       <= ST_WDATA;
        end
        ST_RDATA: if (ev_fall) begin
          if (bitcnt == CNT_LAST) begin
            sda_pull <= 1'b0;
            st       <= ST_RACK;
          end else begin
            sda_pull <= ~shreg[BYTE_W-2];
            shreg    <= {shreg[BYTE_W-2:0], 1'b0};
            bitcnt   <= bitcnt + 1'b1;
          end
        end
        ST_RACK: begin
          if (ev_rise) begin
            ptr <= pair_mate(ptr);
            if (sda_s) st <= ST_IDLE;  // controller refused the byte
          end else if (ev_fall) begin
            shreg    <= rd_data;
            sda_pull <= ~rd_data[BYTE_W-1];
            bitcnt   <= '0;
            st       <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
endmodule

// File: rtl/ioxp_port_ctrl.sv
module ioxp_port_ctrl
  import ioxp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h74,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  input  logic [15:0] pins_i,
  output logic [15:0] drive_o,
  output logic [15:0] dir_o
);
  logic              scl_s, sda_s;
  logic              ev_rise, ev_fall, ev_start, ev_stop;
  logic              ev_addr_miss, ev_cmd_reject;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  link_st_e          link_st;

  ioxp_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  ioxp_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  ioxp_bus_evt u_evt (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop));

  ioxp_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .rd_data(rd_data), .sda_pull(sda_pull_o), .ptr(ptr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ev_addr_miss(ev_addr_miss), .ev_cmd_reject(ev_cmd_reject), .st(link_st));

  ioxp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(ptr), .pins(pins_i), .rd_data(rd_data),
    .drive_bus(drive_o), .dir_bus(dir_o));
endmodule

// File: rtl/ioxp_port_ctrl_chk.sv
module ioxp_port_ctrl_chk
  import ioxp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_pull_o,
  input logic             ev_stop,
  input logic             ev_addr_miss,
  input logic             ev_cmd_reject,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] ptr,
  input logic [15:0]      drive_o,
  input logic [15:0]      dir_o,
  input link_st_e         link_st
);
  p_addr_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_miss |=> !sda_pull_o && link_st == ST_IDLE);

  p_cmd_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_reject |=> !sda_pull_o && link_st == ST_IDLE);

  p_ptr_mate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == {$past(ptr[IDX_W-1:1]), ~$past(ptr[0])});

  p_input_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx[IDX_W-1:1] == GRP_IN) |=> $stable(drive_o) && $stable(dir_o));

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> link_st == ST_IDLE && !sda_pull_o);

  p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s);
endmodule

bind ioxp_port_ctrl ioxp_port_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
  .ev_stop(ev_stop), .ev_addr_miss(ev_addr_miss), .ev_cmd_reject(ev_cmd_reject),
  .wr_en(wr_en), .wr_idx(wr_idx), .ptr(ptr),
  .drive_o(drive_o), .dir_o(dir_o), .link_st(link_st));

// File: tb/ioxp_port_ctrl_tb_top.sv
module ioxp_port_ctrl_tb_top;
  localparam logic [6:0] ADDR = 7'h5A;
  localparam int Q = 10;  // quarter bit in system clocks

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_pull;
  logic        sda_bus;
  logic [15:0] pins = 16'h0000;
  logic [15:0] drive, dir;

  assign sda_bus = sda_m & ~sda_pull;

  ioxp_port_ctrl #(.DEV_ADDR(ADDR), .SYNC_STAGES(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .pins_i(pins), .drive_o(drive), .dir_o(dir));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard queues for read data
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {8'h00, a}, {8'h00, e});
    end
  end

  task automatic hc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; hc(Q);
    scl_m = 1'b1; hc(Q);
    sda_m = 1'b0; hc(Q);
    scl_m = 1'b0; hc(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; hc(Q);
    scl_m = 1'b1; hc(Q);
    sda_m = 1'b1; hc(Q);
  endtask

  task automatic m_bit(input logic b);
    sda_m = b;    hc(Q);
    scl_m = 1'b1; hc(2*Q);
    scl_m = 1'b0; hc(Q);
  endtask

  task automatic m_wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    sda_m = 1'b1; hc(Q);
    scl_m = 1'b1; hc(Q);
    ack = ~sda_bus; hc(Q);
    scl_m = 1'b0; hc(Q);
  endtask

  task automatic m_rd_byte(input logic last);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hc(Q);
      scl_m = 1'b1; hc(Q);
      b[i] = sda_bus; hc(Q);
      scl_m = 1'b0; hc(Q);
    end
    act_q.push_back(b);
    m_bit(last);
  endtask

  task automatic wr_txn(input string tag, input logic [7:0] cmd, input int n,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic ack;
    m_start();
    m_wr_byte({ADDR, 1'b0}, ack); chk({tag, " R1 addr ack"}, 16'(ack), 16'd1);
    m_wr_byte(cmd, ack);          chk({tag, " R2 cmd ack"}, 16'(ack), 16'd1);
    for (int i = 0; i < n; i++) begin
      m_wr_byte(i == 0 ? d0 : (i == 1 ? d1 : d2), ack);
      chk({tag, " R3 data ack"}, 16'(ack), 16'd1);
    end
    chk({tag, " R9 released after ack"}, 16'(sda_pull), 16'd0);
    m_stop();
    hc(Q);
  endtask

  task automatic rd_txn(input string tag, input logic [7:0] cmd, input int n,
                        input logic [7:0] e0, input logic [7:0] e1);
    logic ack;
    m_start();
    m_wr_byte({ADDR, 1'b0}, ack); chk({tag, " R1 addr ack"}, 16'(ack), 16'd1);
    m_wr_byte(cmd, ack);          chk({tag, " R2 cmd ack"}, 16'(ack), 16'd1);
    m_start();
    m_wr_byte({ADDR, 1'b1}, ack); chk({tag, " R4 read addr ack"}, 16'(ack), 16'd1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(i % 2 == 0 ? e0 : e1);
      tag_q.push_back({tag, " R4 read byte"});
      m_rd_byte(i == n - 1);
    end
    chk({tag, " R4 released after nack"}, 16'(sda_pull), 16'd0);
    m_stop();
    hc(Q);
  endtask

  initial begin
    logic ack;
    hc(10);
    chk("R7 drive reset", drive, 16'hFFFF);
    chk("R7 dir reset", dir, 16'hFFFF);
    chk("R7 sda released", 16'(sda_pull), 16'd0);
    rst_n = 1'b1;
    hc(5);

    rd_txn("R7 polarity reset", 8'd4, 2, 8'h00, 8'h00);

    wr_txn("R3 output stream", 8'd2, 3, 8'hA5, 8'h3C, 8'h77);
    chk("R3 R6 output pair alternates", drive, 16'h3C77);

    wr_txn("R3 direction from 7", 8'd7, 2, 8'h12, 8'h34, 8'h00);
    chk("R3 R6 direction 7 then 6", dir, 16'h1234);

    wr_txn("R6 pol high", 8'd5, 1, 8'h0F, 8'h00, 8'h00);
    wr_txn("R6 pol low", 8'd4, 1, 8'hF0, 8'h00, 8'h00);

    pins = 16'hABCD;
    rd_txn("R6 input xor polarity", 8'd0, 3, 8'h3D, 8'hA4);
    rd_txn("R4 output readback", 8'd3, 2, 8'h3C, 8'h77);
    rd_txn("R4 direction readback", 8'd6, 4, 8'h34, 8'h12);

    wr_txn("R5 write input pair", 8'd1, 2, 8'h55, 8'h66, 8'h00);
    chk("R5 drive untouched", drive, 16'h3C77);
    chk("R5 dir untouched", dir, 16'h1234);
    rd_txn("R5 input still pins", 8'd1, 2, 8'hA4, 8'h3D);

    // wrong address
    m_start();
    m_wr_byte({7'h33, 1'b0}, ack); chk("R1 foreign addr nack", 16'(ack), 16'd0);
    m_wr_byte(8'd2, ack);          chk("R1 ignored after miss", 16'(ack), 16'd0);
    m_wr_byte(8'h00, ack);         chk("R1 data ignored", 16'(ack), 16'd0);
    m_stop();
    chk("R1 drive unchanged", drive, 16'h3C77);

    // bad command
    m_start();
    m_wr_byte({ADDR, 1'b0}, ack);  chk("R2 addr ack", 16'(ack), 16'd1);
    m_wr_byte(8'd8, ack);          chk("R2 cmd 8 nack", 16'(ack), 16'd0);
    m_wr_byte(8'h00, ack);         chk("R2 data after bad cmd nack", 16'(ack), 16'd0);
    m_stop();
    m_start();
    m_wr_byte({ADDR, 1'b0}, ack);
    m_wr_byte(8'h83, ack);         chk("R2 cmd 0x83 nack", 16'(ack), 16'd0);
    m_stop();
    chk("R2 drive unchanged", drive, 16'h3C77);
    chk("R2 dir unchanged", dir, 16'h1234);

    // STOP in the middle of a data byte
    m_start();
    m_wr_byte({ADDR, 1'b0}, ack);
    m_wr_byte(8'd2, ack);          chk("R8 cmd ack", 16'(ack), 16'd1);
    m_bit(1'b0); m_bit(1'b0); m_bit(1'b0); m_bit(1'b0);
    m_stop();
    hc(Q);
    chk("R8 sda released after stop", 16'(sda_pull), 16'd0);
    chk("R8 partial byte not stored", drive, 16'h3C77);
    wr_txn("R8 new txn after stop", 8'd3, 1, 8'hC3, 8'h00, 8'h00);
    chk("R8 R9 write after stop", drive, 16'hC377);

    hc(4 * Q);
    chk("scoreboard drained", 16'(exp_q.size()), 16'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule